// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB panel from a single pixel clock. Software programs the visible width and height, the full line and frame lengths, the distance from the leading edge of each sync pulse to the end of its line or frame, and the two sync pulse widths. From these values the block drives horizontal sync, vertical sync and a data-enable strobe, each sync with a selectable level. It also keeps a vertical-blanking status flag with its own interrupt enable, and it holds per-pin output enables that leave the panel pins floating until software releases them.

The raster runs only while a global run bit and a channel run bit are both set. Timing values written during a frame are held in a shadow copy and take effect at the next frame start, so each frame uses one consistent geometry. A read-only start-delay field reports the vertical blanking length, capped at a parameterised limit.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset every register reads zero, except the pin tristate register at word 8, which reads 3'b111. All pin enables are low, data-enable is low, and both syncs sit at their inactive level.
- R2: The raster runs only while word 0 bit 0 (global run) and word 1 bit 0 (channel run) are both set. While either bit is clear, the counters rest at the origin, data-enable is low and both syncs are inactive.
- R3: In the first cycle after the raster starts, both counters are at zero. The pixel counter wraps at the line total (word 3 bits [11:0]) and the line counter wraps at the frame total (word 4 bits [11:0]). Data-enable is high exactly when the pixel count is below the active width (word 2 bits [11:0]) and the line count is below the active height (word 2 bits [27:16]).
- R4: The horizontal sync pulse is active for the pixel counts from T−B up to, but not including, T−B+W. Here T is the line total, B is word 3 bits [27:16] (sync width plus back porch), and W is word 5 bits [11:0].
- R5: The vertical sync pulse is active for the whole of every line whose count lies in [V−C, V−C+S). Here V is the frame total, C is word 4 bits [27:16], and S is word 5 bits [27:16].
- R6: Both syncs are active-high by default. Setting word 6 bit 0 inverts horizontal sync, and setting word 6 bit 1 inverts vertical sync, including their idle levels.
- R7: Word 1 bits [12:8] read the frame total minus the active height, limited to 30. They read 0 when the active height is not below the frame total.
- R8: The blanking flag (word 7 bit 1) rises in the cycle after the counters stand at pixel 0 of line number equal to the active height, provided the active height is below the frame total. A write to word 7 with bit 1 set clears the flag. If the set and the clear fall in the same cycle, the flag stays set.
- R9: The interrupt output equals the blanking flag ANDed with the interrupt enable (word 7 bit 0).
- R10: pin_oe_o[i] is the inverse of word 8 bit i, where bit 0 is horizontal sync, bit 1 is vertical sync and bit 2 is data-enable.
- R11: Writes to words 2 to 6 while the raster runs change the outputs only from the next frame start. A frame start is the cycle after the last pixel of the last line, or the first cycle after the raster starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| irq_o | output | 1 | Vertical-blanking interrupt |
| pin_oe_o | output | 3 | Output enables for hsync, vsync and data-enable pins |

## Verification
The blanking flag has two causes of change: it sets at pixel 0 of the first blanking line, and it clears on an acknowledge write. These two can land on the same clock. The bench uses its reference model to find the exact cycle in which the counters stand at that position, and it issues the acknowledge write in that same cycle. It then expects the flag and the interrupt to remain high, and it confirms this both through the interrupt pin and by reading back the status word. A second collision occurs when a geometry write lands mid-frame while the raster runs. There, every-cycle comparison against the model's shadow copy judges that the old timing holds until the frame wraps.

// File: rtl/lcd_tmg_pkg.sv
package lcd_tmg_pkg;
  parameter int DIM_W   = 12;
  parameter int DATA_W  = 32;
  parameter int ADDR_W  = 4;
  parameter int HALF    = 16;
  parameter int DLY_W   = 5;
  parameter int DLY_LSB = 8;
  parameter int PIN_N   = 3;

  localparam logic [ADDR_W-1:0] A_GLOBAL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CHAN   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ACTIVE = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_HTIME  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VTIME  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SYNCW  = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_POL    = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_IRQ    = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_PINTRI = ADDR_W'(8);

  typedef struct packed {
    logic [DIM_W-1:0] h_act;
    logic [DIM_W-1:0] v_act;
    logic [DIM_W-1:0] h_tot;
    logic [DIM_W-1:0] v_tot;
    logic [DIM_W-1:0] h_bp;
    logic [DIM_W-1:0] v_bp;
    logic [DIM_W-1:0] h_sw;
    logic [DIM_W-1:0] v_sw;
    logic             h_inv;
    logic             v_inv;
  } geom_t;

  // Pulse window [tot-bp, tot-bp+sw) evaluated one bit wider than the counter.
  function automatic logic in_pulse(input logic [DIM_W-1:0] cnt,
                                    input logic [DIM_W-1:0] tot,
                                    input logic [DIM_W-1:0] bp,
                                    input logic [DIM_W-1:0] sw);
    logic [DIM_W:0] start;
    logic [DIM_W:0] stop;
    start = {1'b0, tot} - {1'b0, bp};
    stop  = start + {1'b0, sw};
    return ({1'b0, cnt} >= start) && ({1'b0, cnt} < stop);
  endfunction
endpackage

// File: rtl/lcd_tmg_regs.sv
module lcd_tmg_regs
  import lcd_tmg_pkg::*;
#(
  parameter int DELAY_CAP = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              shadow_load,
  input  logic              vb_flag,
  output logic              run,
  output geom_t             geo_sh,
  output logic              irq_en,
  output logic              wr_ack,
  output logic [PIN_N-1:0]  pin_tri
);
  logic             gen_en_q, gen_en_d;
  logic             ch_en_q,  ch_en_d;
  geom_t            geo_q,    geo_d;
  geom_t            sh_q;
  logic             ien_q,    ien_d;
  logic [PIN_N-1:0] tri_q,    tri_d;
  logic [DLY_W-1:0] dly;
  logic [DIM_W:0]   vb_len;
  logic [DIM_W-1:0] lo_f, hi_f;
  logic             unused_wbits;

  assign lo_f = wdata[DIM_W-1:0];
  assign hi_f = wdata[HALF +: DIM_W];
  assign unused_wbits = ^{wdata[HALF-1:DIM_W], wdata[DATA_W-1:HALF+DIM_W]};

  // next-state for the programmable registers
  always_comb begin
    gen_en_d = gen_en_q;
    ch_en_d  = ch_en_q;
    geo_d    = geo_q;
    ien_d    = ien_q;
    tri_d    = tri_q;
    if (wr_en) begin
      case (addr)
        A_GLOBAL: gen_en_d = wdata[0];
        A_CHAN:   ch_en_d  = wdata[0];
        A_ACTIVE: begin geo_d.h_act = lo_f; geo_d.v_act = hi_f; end
        A_HTIME:  begin geo_d.h_tot = lo_f; geo_d.h_bp  = hi_f; end
        A_VTIME:  begin geo_d.v_tot = lo_f; geo_d.v_bp  = hi_f; end
        A_SYNCW:  begin geo_d.h_sw  = lo_f; geo_d.v_sw  = hi_f; end
        A_POL:    begin geo_d.h_inv = wdata[0]; geo_d.v_inv = wdata[1]; end
        A_IRQ:    ien_d = wdata[0];
        A_PINTRI: tri_d = wdata[PIN_N-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en_q <= 1'b0;
      ch_en_q  <= 1'b0;
      geo_q    <= '0;
      ien_q    <= 1'b0;
      tri_q    <= '1;
    end else begin
      gen_en_q <= gen_en_d;
      ch_en_q  <= ch_en_d;
      geo_q    <= geo_d;
      ien_q    <= ien_d;
      tri_q    <= tri_d;
    end
  end

  // shadow copy, refreshed while idle and at every frame wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sh_q <= '0;
    else if (shadow_load) sh_q <= geo_q;
  end

  // blanking length, capped
  assign vb_len = {1'b0, geo_q.v_tot} - {1'b0, geo_q.v_act};
  always_comb begin
    if (geo_q.v_act >= geo_q.v_tot)              dly = '0;
    else if (vb_len > (DIM_W+1)'(DELAY_CAP))    dly = DLY_W'(DELAY_CAP);
    else                                        dly = vb_len[DLY_W-1:0];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_GLOBAL: rdata[0] = gen_en_q;
      A_CHAN:   begin rdata[0] = ch_en_q; rdata[DLY_LSB +: DLY_W] = dly; end
      A_ACTIVE: begin rdata[DIM_W-1:0] = geo_q.h_act; rdata[HALF +: DIM_W] = geo_q.v_act; end
      A_HTIME:  begin rdata[DIM_W-1:0] = geo_q.h_tot; rdata[HALF +: DIM_W] = geo_q.h_bp;  end
      A_VTIME:  begin rdata[DIM_W-1:0] = geo_q.v_tot; rdata[HALF +: DIM_W] = geo_q.v_bp;  end
      A_SYNCW:  begin rdata[DIM_W-1:0] = geo_q.h_sw;  rdata[HALF +: DIM_W] = geo_q.v_sw;  end
      A_POL:    begin rdata[0] = geo_q.h_inv; rdata[1] = geo_q.v_inv; end
      A_IRQ:    begin rdata[0] = ien_q; rdata[1] = vb_flag; end
      A_PINTRI: rdata[PIN_N-1:0] = tri_q;
      default:  rdata = '0;
    endcase
  end

  assign run     = gen_en_q & ch_en_q;
  assign geo_sh  = sh_q;
  assign irq_en  = ien_q;
  assign wr_ack  = wr_en && (addr == A_IRQ) && wdata[1];
  assign pin_tri = tri_q;
endmodule

// File: rtl/lcd_tmg_count.sv
module lcd_tmg_count
  import lcd_tmg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIM_W-1:0] h_tot,
  input  logic [DIM_W-1:0] v_tot,
  output logic [DIM_W-1:0] hcnt,
  output logic [DIM_W-1:0] vcnt,
  output logic             frame_end
);
  logic [DIM_W-1:0] hcnt_q, hcnt_d;
  logic [DIM_W-1:0] vcnt_q, vcnt_d;
  logic             line_end;

  assign line_end  = ({1'b0, hcnt_q} + (DIM_W+1)'(1)) >= {1'b0, h_tot};
  assign frame_end = run && line_end &&
                     (({1'b0, vcnt_q} + (DIM_W+1)'(1)) >= {1'b0, v_tot});

  always_comb begin
    hcnt_d = hcnt_q;
    vcnt_d = vcnt_q;
    if (!run) begin
      hcnt_d = '0;
      vcnt_d = '0;
    end else if (line_end) begin
      hcnt_d = '0;
      vcnt_d = frame_end ? '0 : vcnt_q + DIM_W'(1);
    end else begin
      hcnt_d = hcnt_q + DIM_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_d;
      vcnt_q <= vcnt_d;
    end
  end

  assign hcnt = hcnt_q;
  assign vcnt = vcnt_q;
endmodule

// File: rtl/lcd_tmg_decode.sv
module lcd_tmg_decode
  import lcd_tmg_pkg::*;
(
  input  logic             run,
  input  logic [DIM_W-1:0] hcnt,
  input  logic [DIM_W-1:0] vcnt,
  input  geom_t            geo,
  output logic             hsync,
  output logic             vsync,
  output logic             de
);
  localparam int AXES = 2;

  logic [DIM_W-1:0] a_cnt [AXES];
  logic [DIM_W-1:0] a_tot [AXES];
  logic [DIM_W-1:0] a_bp  [AXES];
  logic [DIM_W-1:0] a_sw  [AXES];
  logic [AXES-1:0]  a_inv;
  logic [AXES-1:0]  pulse;
  logic [AXES-1:0]  level;

  assign a_cnt[0] = hcnt;       assign a_cnt[1] = vcnt;
  assign a_tot[0] = geo.h_tot;  assign a_tot[1] = geo.v_tot;
  assign a_bp[0]  = geo.h_bp;   assign a_bp[1]  = geo.v_bp;
  assign a_sw[0]  = geo.h_sw;   assign a_sw[1]  = geo.v_sw;
  assign a_inv    = {geo.v_inv, geo.h_inv};

  for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
    assign pulse[ax] = run && in_pulse(a_cnt[ax], a_tot[ax], a_bp[ax], a_sw[ax]);
    assign level[ax] = pulse[ax] ^ a_inv[ax];
  end

  assign hsync = level[0];
  assign vsync = level[1];
  assign de    = run && (hcnt < geo.h_act) && (vcnt < geo.v_act);
endmodule

// File: rtl/lcd_tmg_vblank.sv
module lcd_tmg_vblank
  import lcd_tmg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIM_W-1:0] hcnt,
  input  logic [DIM_W-1:0] vcnt,
  input  logic [DIM_W-1:0] v_act,
  input  logic [DIM_W-1:0] v_tot,
  input  logic             ack,
  output logic             flag
);
  logic flag_q, flag_d, set_ev;

  assign set_ev = run && (hcnt == '0) && (vcnt == v_act) && (v_act < v_tot);

  // a set event outranks an acknowledge in the same cycle
  always_comb flag_d = set_ev | (flag_q & ~ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_tmg_pkg::*;
#(
  parameter int DELAY_CAP = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              irq_o,
  output logic [PIN_N-1:0]  pin_oe_o
);
  logic             rst_s1, rst_sync_n;
  logic             run, frame_end, vb_flag, wr_ack, irq_en;
  logic [DIM_W-1:0] hcnt, vcnt;
  logic [PIN_N-1:0] pin_tri;
  geom_t            geo_sh;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  lcd_tmg_regs #(.DELAY_CAP(DELAY_CAP)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .shadow_load(!run || frame_end), .vb_flag(vb_flag),
    .run(run), .geo_sh(geo_sh), .irq_en(irq_en), .wr_ack(wr_ack),
    .pin_tri(pin_tri)
  );

  lcd_tmg_count u_count (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .h_tot(geo_sh.h_tot),
    .v_tot(geo_sh.v_tot), .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end)
  );

  lcd_tmg_decode u_decode (
    .run(run), .hcnt(hcnt), .vcnt(vcnt), .geo(geo_sh),
    .hsync(hsync_o), .vsync(vsync_o), .de(de_o)
  );

  lcd_tmg_vblank u_vblank (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .hcnt(hcnt), .vcnt(vcnt),
    .v_act(geo_sh.v_act), .v_tot(geo_sh.v_tot), .ack(wr_ack), .flag(vb_flag)
  );

  assign irq_o    = vb_flag & irq_en;
  assign pin_oe_o = ~pin_tri;
endmodule

// File: rtl/lcd_raster_timer_chk.sv
module lcd_raster_timer_chk
  import lcd_tmg_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              run,
  input logic              frame_end,
  input logic [DIM_W-1:0]  hcnt,
  input logic [DIM_W-1:0]  vcnt,
  input geom_t             geo_sh,
  input logic              vb_flag,
  input logic              wr_ack,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              de_o,
  input logic              irq_o,
  input logic [PIN_N-1:0]  pin_oe_o
);
  p_start_origin_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(run) |-> (hcnt == '0 && vcnt == '0));

  p_idle_dark_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run |-> !de_o);

  p_h_bound_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && geo_sh.h_tot != '0) |-> (hcnt < geo_sh.h_tot));

  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(vb_flag) |-> $past(run && hcnt == '0 && vcnt == geo_sh.v_act));

  p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(vb_flag) |-> $past(wr_ack));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> vb_flag);

  p_oe_by_write_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(pin_oe_o) |-> $past(wr_en && addr == A_PINTRI));

  p_geom_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (run && $past(run) && !$past(frame_end)) |-> $stable(geo_sh));
endmodule

bind lcd_raster_timer lcd_raster_timer_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .run(run), .frame_end(frame_end),
  .hcnt(hcnt), .vcnt(vcnt), .geo_sh(geo_sh), .vb_flag(vb_flag),
  .wr_ack(wr_ack), .wr_en(wr_en), .addr(addr), .de_o(de_o),
  .irq_o(irq_o), .pin_oe_o(pin_oe_o)
);

// File: tb/tb_lcd_raster_timer.sv
module tb_lcd_raster_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        hsync_o, vsync_o, de_o, irq_o;
  logic [2:0]  pin_oe_o;

  always #5 clk = ~clk;

  lcd_raster_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .irq_o(irq_o), .pin_oe_o(pin_oe_o)
  );

  int n_chk = 0, n_fail = 0;
  bit cmp_on = 0, done = 0;

  // reference model state: live registers, shadow copy, counters, flag
  int m_gen = 0, m_ch = 0, m_ien = 0, m_flag = 0, m_tri = 7;
  int l_hact = 0, l_vact = 0, l_htot = 0, l_vtot = 0, l_hbp = 0, l_vbp = 0;
  int l_hsw = 0, l_vsw = 0, l_hinv = 0, l_vinv = 0;
  int s_hact = 0, s_vact = 0, s_htot = 0, s_vtot = 0, s_hbp = 0, s_vbp = 0;
  int s_hsw = 0, s_vsw = 0, s_hinv = 0, s_vinv = 0;
  int hc = 0, vc = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  function automatic void take_shadow();
    s_hact = l_hact; s_vact = l_vact; s_htot = l_htot; s_vtot = l_vtot;
    s_hbp = l_hbp; s_vbp = l_vbp; s_hsw = l_hsw; s_vsw = l_vsw;
    s_hinv = l_hinv; s_vinv = l_vinv;
  endfunction

  function automatic int exp_read(int a);
    int dly;
    dly = (l_vact >= l_vtot) ? 0 : ((l_vtot - l_vact > 30) ? 30 : l_vtot - l_vact);
    case (a)
      0: return m_gen;
      1: return m_ch | (dly << 8);
      2: return l_hact | (l_vact << 16);
      3: return l_htot | (l_hbp << 16);
      4: return l_vtot | (l_vbp << 16);
      5: return l_hsw | (l_vsw << 16);
      6: return l_hinv | (l_vinv << 1);
      7: return m_ien | (m_flag << 1);
      8: return m_tri;
      default: return 0;
    endcase
  endfunction

  // model advances on the same edge as the design
  always @(posedge clk) begin
    int run_old, set_ev, clr, d;
    run_old = m_gen && m_ch;
    set_ev  = run_old && hc == 0 && vc == s_vact && s_vact < s_vtot;
    clr     = wr_en && addr == 7 && wdata[1];
    if (!run_old) begin
      hc = 0; vc = 0; take_shadow();
    end else if (hc + 1 >= s_htot) begin
      hc = 0;
      if (vc + 1 >= s_vtot) begin vc = 0; take_shadow(); end
      else vc++;
    end else hc++;
    m_flag = (set_ev || (m_flag && !clr)) ? 1 : 0;
    if (wr_en) begin
      d = int'(wdata);
      case (addr)
        0: m_gen = d & 1;
        1: m_ch  = d & 1;
        2: begin l_hact = d & 'hfff; l_vact = (d >> 16) & 'hfff; end
        3: begin l_htot = d & 'hfff; l_hbp  = (d >> 16) & 'hfff; end
        4: begin l_vtot = d & 'hfff; l_vbp  = (d >> 16) & 'hfff; end
        5: begin l_hsw  = d & 'hfff; l_vsw  = (d >> 16) & 'hfff; end
        6: begin l_hinv = d & 1; l_vinv = (d >> 1) & 1; end
        7: m_ien = d & 1;
        8: m_tri = d & 7;
        default: ;
      endcase
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int run, hs, vs, e_de, hst, vst;
    if (cmp_on && !done) begin
      run  = m_gen && m_ch;
      hst  = s_htot - s_hbp;
      vst  = s_vtot - s_vbp;
      hs   = (run && hc >= hst && hc < hst + s_hsw) ? 1 : 0;
      vs   = (run && vc >= vst && vc < vst + s_vsw) ? 1 : 0;
      e_de = (run && hc < s_hact && vc < s_vact) ? 1 : 0;
      chk("R2/R3/R11 de", int'(de_o), e_de);
      chk("R4/R6/R11 hsync", int'(hsync_o), hs ^ s_hinv);
      chk("R5/R6/R11 vsync", int'(vsync_o), vs ^ s_vinv);
      chk("R8/R9 irq", int'(irq_o), m_flag & m_ien);
      chk("R10 pin_oe", int'(pin_oe_o), (~m_tri) & 7);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, int a);
    @(negedge clk);
    addr = 4'(a);
    #1;
    chk(req, int'(rdata), exp_read(a));
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);
    cmp_on = 1;
    // R1: reset values
    for (int a = 0; a <= 8; a++) rd("R1 reset read", a);
    chk("R1 pin_oe after reset", int'(pin_oe_o), 0);

    // geometry A: 10x7 raster, 6x4 visible
    wr(2, 6 | (4 << 16));
    wr(3, 10 | (3 << 16));
    wr(4, 7 | (2 << 16));
    wr(5, 2 | (1 << 16));
    wr(7, 1);
    wr(8, 0);                          // R10: release pins
    rd("R7 delay 3", 1);
    wr(0, 1);                          // R2: global alone does not run
    cycles(20);
    wr(1, 1);
    cycles(150);                       // R3 R4 R5 R8 R9 across two frames

    // R8: plain acknowledge clears the flag
    wr(7, 3);
    rd("R8 flag cleared", 7);

    // R8: acknowledge lands in the set cycle; set wins
    do @(negedge clk); while (!(hc == 0 && vc == s_vact));
    wr_en = 1'b1; addr = 4'd7; wdata = 32'd3;
    @(negedge clk);
    wr_en = 1'b0;
    rd("R8 collision keeps flag", 7);
    wr(7, 3);

    // R11: mid-frame geometry and polarity change
    do @(negedge clk); while (!(vc == 1 && hc == 2));
    wr(2, 5 | (3 << 16));
    wr(6, 3);                          // R6: invert both syncs
    cycles(150);

    // R2: drop global run mid-frame, then restart
    cycles(13);
    wr(0, 0);
    cycles(12);
    wr(0, 1);
    cycles(40);

    // R7: cap and zero cases, with channel stopped
    wr(1, 0);
    wr(4, 40 | (5 << 16));
    wr(2, 6 | (2 << 16));
    rd("R7 delay capped", 1);
    wr(2, 6 | (50 << 16));
    rd("R7 delay zero", 1);
    wr(2, 6 | (2 << 16));
    wr(6, 0);
    wr(1, 1);
    cycles(820);                       // R5 long blanking frames

    // R9: enable off hides a set flag
    wr(7, 0);
    cycles(420);
    rd("R9 flag readback", 7);

    // R10: partial tristate
    wr(8, 5);
    cycles(5);
    chk("R10 partial pin_oe", int'(pin_oe_o), 2);
    rd("R10 tri readback", 8);
    finish_run();
  end
endmodule